// File: doc/BRIEF.md
# Armed Circular Trace Buffer

This block records a stream of data words into a 64-entry ring while it is armed. Each accepted capture strobe stores one word at the current write position and advances a 6-bit count. When the count wraps from 63 back to 0, a sticky full flag is set. From then on, all 64 entries are valid and the oldest one sits at the count position. Arming the block clears both the count and the flag.

The trigger-mode input selects what happens once the buffer holds 64 words:
- **Begin-trigger mode:** the buffer disarms itself, which keeps the first 64 words after arming.
- **End-trigger mode:** capture continues and overwrites the oldest word, which keeps the most recent 64 words.

On the capture that first brings the buffer to 64 words, the block can emit a one-cycle breakpoint pulse.

There are two read-side outputs:
- **Status byte:** carries the full flag and the count.
- **Indexed read port:** returns stored words in age order, with index 0 always the oldest.

Top module: `trace_ring`

## Requirements
- R1: After reset the block is disarmed, the status byte is 0x00 and the breakpoint output is low.
- R2: A cycle with `arm_set` high sets the armed state and clears the count and the full flag. A capture strobe in that same cycle is not stored.
- R3: While disarmed, a capture strobe changes neither the status byte nor any stored word.
- R4: The status byte carries the full flag in bit 7, zero in bit 6 and the count in bits 5:0. Each accepted capture stores the word at position `count` and raises the count by one, modulo 64.
- R5: The full flag is set by the capture that moves the count from 63 to 0. It then stays set until the next `arm_set`.
- R6: With `end_mode` low, the capture that sets the full flag also disarms the block. Later strobes store nothing, and the first 64 captured words stay in place.
- R7: With `end_mode` high, capture continues after the full flag is set. Each new word replaces the oldest stored word.
- R8: `rd_data` for index k returns the k-th oldest valid word. That is entry k while the flag is clear, and entry (count + k) mod 64 while it is set.
- R9: `brk_pulse` is high for exactly one cycle after the capture that sets the full flag, and only if `brk_en` was high at that capture. Later wraps in end-trigger mode do not repeat it.
- R10: A cycle with `arm_clr` high (and `arm_set` low) disarms the block. The count, the flag and the stored words are kept, and a capture strobe in that cycle is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_set | input | 1 | Arm and clear count and full flag |
| arm_clr | input | 1 | Disarm, keeping contents |
| end_mode | input | 1 | 1: wrap and overwrite; 0: stop at 64 words |
| brk_en | input | 1 | Enable breakpoint pulse on reaching 64 words |
| cap_valid | input | 1 | Capture strobe |
| cap_data | input | DATA_W | Word to capture |
| rd_idx | input | 6 | Age index, 0 = oldest |
| rd_data | output | DATA_W | Word at the requested age |
| status | output | 8 | {full, 0, count[5:0]} |
| armed | output | 1 | Block is accepting captures |
| brk_pulse | output | 1 | One-cycle breakpoint pulse |

## Verification
The bench drives end-trigger mode through more than two full wraps and reads back all valid ages after every capture. A design that rotates the read index wrongly would return the ages in the wrong order. A design whose flag fails to stick would show the rollover as an empty buffer.

In begin-trigger mode, the bench keeps strobing after the 64th word. A design that fails to disarm would overwrite the earliest words.

Strobes are also sent while disarmed and in the same cycle as arming or disarming. These expose a design that lets a stray capture move the count.

The breakpoint is watched on every capture with the enable both set and clear, and across the second wrap. A pulse repeated at every rollover, or one that ignores the enable, is reported.

// File: rtl/trace_ring.sv
module trace_ring #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_set,
  input  logic              arm_clr,
  input  logic              end_mode,
  input  logic              brk_en,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [7:0]        status,
  output logic              armed,
  output logic              brk_pulse
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] cnt;
  logic              full;
  logic              fire;
  logic              wrap;
  logic [ADDR_W-1:0] rd_ptr;

  assign fire = armed & cap_valid & ~arm_set & ~arm_clr;
  assign wrap = fire & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      cnt       <= '0;
      full      <= 1'b0;
      brk_pulse <= 1'b0;
    end else begin
      brk_pulse <= wrap & ~full & brk_en;
      if (arm_set) begin
        armed <= 1'b1;
        cnt   <= '0;
        full  <= 1'b0;
      end else if (arm_clr) begin
        armed <= 1'b0;
      end else if (fire) begin
        cnt <= cnt + 1'b1;
        if (wrap) begin
          full <= 1'b1;
          if (!end_mode) armed <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fire) mem[cnt] <= cap_data;
  end

  assign rd_ptr  = full ? cnt + rd_idx : rd_idx;
  assign rd_data = mem[rd_ptr];
  assign status  = {full, 1'b0, {(6 - ADDR_W){1'b0}}, cnt};

  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_set |=> (status == 8'h00) && armed);

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !arm_set) |=> $stable(status));

  assert_full_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !arm_set) |=> status[7]);

  assert_begin_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status[7]) && !$past(end_mode)) |-> !armed);

  assert_brk_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> $rose(status[7]));

  assert_brk_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |=> !brk_pulse);

  assert_disarm_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_clr && !arm_set) |=> !armed && $stable(status));
endmodule

// File: tb/trace_ring_test.sv
module trace_ring_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm_set = 1'b0, arm_clr = 1'b0, end_mode = 1'b0, brk_en = 1'b0;
  logic        cap_valid = 1'b0;
  logic [15:0] cap_data = '0;
  logic [5:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic [7:0]  status;
  logic        armed, brk_pulse;
  int vectors = 0, fails = 0;

  always #10 clk = ~clk;

  trace_ring uut (.clk, .rst_n, .arm_set, .arm_clr, .end_mode, .brk_en,
                  .cap_valid, .cap_data, .rd_idx, .rd_data, .status,
                  .armed, .brk_pulse);

  function automatic logic [15:0] wd(int s, int i);
    return 16'(s * 4099 + i * 37 + 5);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cap(logic [15:0] d);
    @(negedge clk); cap_valid = 1'b1; cap_data = d;
    @(negedge clk); cap_valid = 1'b0;
  endtask

  task automatic do_arm(logic with_cap);
    @(negedge clk); arm_set = 1'b1; cap_valid = with_cap; cap_data = 16'hdead;
    @(negedge clk); arm_set = 1'b0; cap_valid = 1'b0;
  endtask

  task automatic read_k(int k, logic [15:0] exp, string req);
    rd_idx = 6'(k); #1;
    chk(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic run_end(int s, int total);
    for (int n = 1; n <= total; n++) begin
      cap(wd(s, n - 1));
      chk("R4/R5 status", 32'(status), 32'({n >= 64, 1'b0, 6'(n % 64)}));
      chk("R9 brk", 32'(brk_pulse), 32'(n == 64));
      chk("R7 armed", 32'(armed), 32'd1);
      for (int k = 0; k < 64; k++) begin
        if (n >= 64) read_k(k, wd(s, n - 64 + k), "R8/R7 ring read");
        else if (k < n) read_k(k, wd(s, k), "R8/R4 linear read");
      end
      @(negedge clk);
      chk("R9 brk width", 32'(brk_pulse), 32'd0);
    end
  endtask

  task automatic run_begin(int s, logic be);
    brk_en = be; end_mode = 1'b0;
    do_arm(1'b0);
    for (int n = 1; n <= 64; n++) begin
      cap(wd(s, n - 1));
      chk("R9 brk enable", 32'(brk_pulse), 32'(be && n == 64));
      chk("R6 armed", 32'(armed), 32'(n != 64));
    end
    for (int n = 0; n < 5; n++) cap(16'hbeef);
    chk("R6 status held", 32'(status), 32'h80);
    chk("R6 still disarmed", 32'(armed), 32'd0);
    for (int k = 0; k < 64; k++) read_k(k, wd(s, k), "R6 first words kept");
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", 32'(status), 32'h00);
    chk("R1 armed", 32'(armed), 32'd0);
    chk("R1 brk", 32'(brk_pulse), 32'd0);
    rst_n = 1'b1;
    for (int n = 0; n < 3; n++) cap(16'h1234);
    chk("R3 idle status", 32'(status), 32'h00);

    end_mode = 1'b1; brk_en = 1'b1;
    do_arm(1'b1);
    chk("R2 arm status", 32'(status), 32'h00);
    chk("R2 armed", 32'(armed), 32'd1);
    run_end(1, 140);

    @(negedge clk); arm_clr = 1'b1; cap_valid = 1'b1; cap_data = 16'h5555;
    @(negedge clk); arm_clr = 1'b0; cap_valid = 1'b0;
    chk("R10 disarmed", 32'(armed), 32'd0);
    chk("R10 status kept", 32'(status), 32'h8c);
    for (int n = 0; n < 5; n++) cap(16'h7777);
    chk("R3 status kept", 32'(status), 32'h8c);
    for (int k = 0; k < 64; k++) read_k(k, wd(1, 76 + k), "R3/R10 contents kept");

    run_begin(2, 1'b0);
    run_begin(3, 1'b1);

    do_arm(1'b1);
    chk("R5/R2 rearm clears full", 32'(status), 32'h00);
    cap(wd(4, 0));
    chk("R2 same-cycle capture dropped", 32'(status), 32'h01);
    read_k(0, wd(4, 0), "R2/R4 first word");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule